// File: doc/BRIEF.md
# Oscillator Amplitude Search Controller

This block is the digital half of an amplitude regulation loop for a crystal oscillator. It runs on a clock taken from the oscillator itself and drives an 8-bit bias-current code. Two comparator flags report the measured swing: one is set when the swing is below the lower window limit, the other when it is above the upper limit. After each code change the controller waits a fixed settling interval, because a high-Q crystal takes a long time to reach a new amplitude. Only then does it read the flags.

The search halves its step at every decision. The code starts at midscale and the first step is a quarter of full scale. The search stops as soon as neither flag is set. It also stops after the step of one has been applied, so the loop cannot hunt without end. A boost output shortens start-up and is dropped at the first decision. Two constant select outputs program the reference generator that sets the window limits.

Top module: `amp_search_ctrl`

## Requirements
- R1: While reset is asserted and just after it, bias_code is 128, boost_en is 1, and search_done, in_window and flag_err are 0.
- R2: A decision is taken on the SETTLE_CYCLES-th rising clock edge after reset release, and again every SETTLE_CYCLES edges after the previous decision. bias_code changes on no other edge.
- R3: The first step is 64 and each later step is half the previous one. For example, amp_low at the first decision gives 192, and amp_high at the second gives 160.
- R4: amp_low alone at a decision raises the code by the current step. amp_high alone lowers it by the current step.
- R5: If both flags are 0 at a decision, the code holds, search_done becomes 1 and in_window becomes 1.
- R6: If the step is already 1 and one flag is set, that step is applied, then search_done becomes 1 and in_window stays 0.
- R7: If both flags are 1 at a decision, the code and step hold, flag_err becomes 1 and stays 1 until reset, and the search continues.
- R8: The code saturates at 0 and 255 and never wraps. Raising at every decision ends at 255; lowering at every decision ends at 1.
- R9: boost_en falls at the first decision and stays 0 until reset.
- R10: Once search_done is 1, it stays 1 and bias_code, in_window and flag_err stay fixed until reset, whatever the flags do.
- R11: win_lo_sel and win_hi_sel always show the parameters LO_SEL and HI_SEL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock derived from the running oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| amp_low | input | 1 | Swing is below the lower window limit (request increase) |
| amp_high | input | 1 | Swing is above the upper window limit (request decrease) |
| bias_code | output | CODE_W | Bias-current code for the current DAC |
| boost_en | output | 1 | Start-up current boost |
| search_done | output | 1 | Search has ended |
| in_window | output | 1 | Search ended with the swing inside the window |
| flag_err | output | 1 | Both flags were seen at once at a decision |
| win_lo_sel | output | SEL_W | Lower window limit select for the reference generator |
| win_hi_sel | output | SEL_W | Upper window limit select for the reference generator |

## Verification
The assertions assume that both flags are synchronous to the oscillator clock. The controller reads them only on a decision edge, so their values between decisions do not matter. The bench changes the flags just after a rising edge and holds them for a whole settling window. It deliberately drives the conflicting pair, and keeps toggling the flags after the search has ended, to check that they are then ignored. The settling interval is shortened by parameter, so that several complete searches fit in one run.

// File: rtl/amp_search_pkg.sv
package amp_search_pkg;
    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_DONE   = 1'b1
    } srch_state_e;

    typedef enum logic [1:0] {
        DEC_HOLD     = 2'd0,
        DEC_RAISE    = 2'd1,
        DEC_LOWER    = 2'd2,
        DEC_CONFLICT = 2'd3
    } decision_e;

    function automatic decision_e classify(input logic low_f, input logic high_f);
        case ({low_f, high_f})
            2'b10:   return DEC_RAISE;
            2'b01:   return DEC_LOWER;
            2'b11:   return DEC_CONFLICT;
            default: return DEC_HOLD;
        endcase
    endfunction
endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int unsigned CYCLES = 75000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (run) begin
            if (tmr_q.cnt == LAST) begin
                tmr_d.cnt = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign tick = run && (tmr_q.cnt == LAST);

    // R2: the counter never passes the end of the settling window
    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= LAST);

    // R2: a tick restarts the window
    assert_restart_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (tmr_q.cnt == '0));
endmodule

// File: rtl/code_stepper.sv
module code_stepper #(
    parameter int unsigned CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply,
    input  logic              raise,
    output logic [CODE_W-1:0] code,
    output logic              last_step
);
    localparam logic [CODE_W-1:0] INIT_CODE = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] INIT_STEP = CODE_W'(1) << (CODE_W - 2);
    localparam logic [CODE_W-1:0] CODE_MAX  = '1;
    localparam logic [CODE_W-1:0] ONE       = CODE_W'(1);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CODE_W-1:0] step;
    } stp_t;

    stp_t stp_d, stp_q;
    logic [CODE_W:0] sum_w;
    logic [CODE_W:0] diff_w;

    always_comb begin
        stp_d  = stp_q;
        sum_w  = {1'b0, stp_q.code} + {1'b0, stp_q.step};
        diff_w = {1'b0, stp_q.code} - {1'b0, stp_q.step};
        if (apply) begin
            if (raise) begin
                stp_d.code = sum_w[CODE_W] ? CODE_MAX : sum_w[CODE_W-1:0];
            end else begin
                stp_d.code = diff_w[CODE_W] ? '0 : diff_w[CODE_W-1:0];
            end
            if (stp_q.step > ONE) begin
                stp_d.step = stp_q.step >> 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stp_q.code <= INIT_CODE;
            stp_q.step <= INIT_STEP;
        end else begin
            stp_q <= stp_d;
        end
    end

    assign code      = stp_q.code;
    assign last_step = (stp_q.step == ONE);

    // R8: a raise never lowers the code (no wrap)
    assert_raise_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && raise) |=> (code >= $past(code)));

    // R8: a lowering never raises the code (no wrap)
    assert_lower_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && !raise) |=> (code <= $past(code)));

    // R4: without an applied step the code holds
    assert_hold_without_apply_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(code));
endmodule

// File: rtl/amp_search_ctrl.sv
module amp_search_ctrl
    import amp_search_pkg::*;
#(
    parameter int unsigned          CODE_W        = 8,
    parameter int unsigned          SETTLE_CYCLES = 75000,
    parameter int unsigned          SEL_W         = 4,
    parameter logic [SEL_W-1:0]     LO_SEL        = 4'd5,
    parameter logic [SEL_W-1:0]     HI_SEL        = 4'd10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              amp_low,
    input  logic              amp_high,
    output logic [CODE_W-1:0] bias_code,
    output logic              boost_en,
    output logic              search_done,
    output logic              in_window,
    output logic              flag_err,
    output logic [SEL_W-1:0]  win_lo_sel,
    output logic [SEL_W-1:0]  win_hi_sel
);
    typedef struct packed {
        srch_state_e      state;
        logic             boost;
        logic             inwin;
        logic             err;
        logic [SEL_W-1:0] lo_sel;
        logic [SEL_W-1:0] hi_sel;
    } ctl_t;

    ctl_t      ctl_d, ctl_q;
    logic      tick;
    logic      apply_step;
    logic      last_step;
    decision_e dec;

    settle_timer #(.CYCLES(SETTLE_CYCLES)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctl_q.state == ST_SEARCH),
        .tick  (tick)
    );

    code_stepper #(.CODE_W(CODE_W)) i_stepper (
        .clk       (clk),
        .rst_n     (rst_n),
        .apply     (apply_step),
        .raise     (amp_low),
        .code      (bias_code),
        .last_step (last_step)
    );

    always_comb begin
        ctl_d      = ctl_q;
        dec        = classify(amp_low, amp_high);
        apply_step = 1'b0;
        if (tick) begin
            ctl_d.boost = 1'b0;
            case (dec)
                DEC_CONFLICT: ctl_d.err = 1'b1;
                DEC_HOLD: begin
                    ctl_d.state = ST_DONE;
                    ctl_d.inwin = 1'b1;
                end
                default: begin
                    apply_step = 1'b1;
                    if (last_step) begin
                        ctl_d.state = ST_DONE;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state  <= ST_SEARCH;
            ctl_q.boost  <= 1'b1;
            ctl_q.inwin  <= 1'b0;
            ctl_q.err    <= 1'b0;
            ctl_q.lo_sel <= LO_SEL;
            ctl_q.hi_sel <= HI_SEL;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign boost_en    = ctl_q.boost;
    assign search_done = (ctl_q.state == ST_DONE);
    assign in_window   = ctl_q.inwin;
    assign flag_err    = ctl_q.err;
    assign win_lo_sel  = ctl_q.lo_sel;
    assign win_hi_sel  = ctl_q.hi_sel;

    // R2: the code only moves on the edge after a decision point
    assert_code_moves_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(bias_code));

    // R5: both flags low at a decision ends the search inside the window
    assert_window_hit_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !amp_low && !amp_high) |=> (search_done && in_window && $stable(bias_code)));

    // R7: a conflicting pair holds the code and raises the error flag
    assert_conflict_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && amp_low && amp_high) |=> (flag_err && $stable(bias_code) && !search_done));

    // R7: the error flag is sticky
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_err |=> flag_err);

    // R9: boost never comes back after it falls
    assert_boost_stays_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !boost_en |=> !boost_en);

    // R9: the first decision drops boost
    assert_boost_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !boost_en);

    // R10: the finished state freezes all results
    assert_done_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        search_done |=> (search_done && $stable(bias_code) && $stable(in_window) && $stable(flag_err)));
endmodule

// File: tb/test_amp_search_ctrl.sv
module test_amp_search_ctrl;
    localparam int N = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       amp_low = 1'b0;
    logic       amp_high = 1'b0;
    logic [7:0] bias_code;
    logic       boost_en, search_done, in_window, flag_err;
    logic [3:0] win_lo_sel, win_hi_sel;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    int m_code, m_step, m_cnt;
    bit m_boost, m_done, m_inw, m_err;

    always #5 clk = ~clk;

    amp_search_ctrl #(
        .CODE_W(8), .SETTLE_CYCLES(N), .SEL_W(4), .LO_SEL(4'd5), .HI_SEL(4'd10)
    ) i_amp_search_ctrl (
        .clk(clk), .rst_n(rst_n), .amp_low(amp_low), .amp_high(amp_high),
        .bias_code(bias_code), .boost_en(boost_en), .search_done(search_done),
        .in_window(in_window), .flag_err(flag_err),
        .win_lo_sel(win_lo_sel), .win_hi_sel(win_hi_sel)
    );

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_code = 128; m_step = 64; m_cnt = 0;
            m_boost = 1; m_done = 0; m_inw = 0; m_err = 0;
        end else if (!m_done) begin
            if (m_cnt == N - 1) begin
                m_cnt = 0;
                m_boost = 0;
                if (amp_low && amp_high) begin
                    m_err = 1;
                end else if (!amp_low && !amp_high) begin
                    m_done = 1; m_inw = 1;
                end else begin
                    if (amp_low) m_code = (m_code + m_step > 255) ? 255 : m_code + m_step;
                    else         m_code = (m_code - m_step < 0) ? 0 : m_code - m_step;
                    if (m_step == 1) m_done = 1;
                    else m_step = m_step / 2;
                end
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2/R3/R4 bias_code", bias_code, m_code);
            check("R9 boost_en", boost_en, m_boost);
            check("R5/R10 search_done", search_done, m_done);
            check("R5/R6 in_window", in_window, m_inw);
            check("R7 flag_err", flag_err, m_err);
            check("R11 win_lo_sel", win_lo_sel, 5);
            check("R11 win_hi_sel", win_hi_sel, 10);
        end
    end

    task automatic do_reset();
        @(posedge clk); #2;
        rst_n = 0; amp_low = 0; amp_high = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1 code", bias_code, 128);
        check("R1 boost", boost_en, 1);
        check("R1 done", search_done, 0);
        check("R1 in_window", in_window, 0);
        check("R1 err", flag_err, 0);
    endtask

    // hold a flag pair across one full settling window
    task automatic window(input bit lo, input bit hi);
        amp_low = lo; amp_high = hi;
        repeat (N) @(posedge clk);
        #2;
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R3 R5: raise, lower, then in window
        do_reset();
        #2;
        window(1, 0);
        window(0, 1);
        window(0, 0);
        @(negedge clk);
        check("R3 code after 2 steps", bias_code, 160);
        check("R5 in_window", in_window, 1);
        // R10: flags ignored once finished
        window(1, 0);
        window(0, 1);
        @(negedge clk);
        check("R10 code frozen", bias_code, 160);

        // R6 R8: raise every time
        do_reset();
        #2;
        for (int i = 0; i < 8; i++) window(1, 0);
        @(negedge clk);
        check("R8 code top", bias_code, 255);
        check("R6 done", search_done, 1);
        check("R6 not in window", in_window, 0);

        // R8: lower every time
        do_reset();
        #2;
        for (int i = 0; i < 8; i++) window(0, 1);
        @(negedge clk);
        check("R8 code bottom", bias_code, 1);

        // R7: conflict then continue
        do_reset();
        #2;
        window(1, 1);
        @(negedge clk);
        check("R7 code held", bias_code, 128);
        check("R7 err", flag_err, 1);
        #2;
        window(0, 1);
        window(1, 0);
        window(0, 0);
        @(negedge clk);
        check("R7 search continued", bias_code, 96);
        check("R7 err sticky", flag_err, 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule